// File: doc/BRIEF.md
# Byte-wide configuration loader with startup sequencer

A host writes configuration data into this block one byte at a time over an asynchronous 8-bit parallel bus. The block brings the host's write strobe into its own clock domain. It accepts a byte only when it is idle, then sends that byte out most significant bit first, one bit per clock, with a valid strobe on each bit. A ready/busy output tells the host when the next byte may be written. That output shows busy only while a byte is being shifted out. An external DONE level never changes it.

A programmed length sets how many bytes the configuration takes. Once that many bytes have been fully shifted out, the block stops pulling the open-drain DONE line low and runs a short startup sequence that ends by releasing the user I/Os. A sync-to-DONE option makes the sequence wait until the DONE pin is actually seen high, so that an external agent holding DONE low can stall startup. With the option clear, the pin level is ignored. The ready/busy output is driven until the user I/Os are released and is let go after that.

Top module: `cfg_byte_loader`

## Requirements
- R1: While reset is asserted (rst_n low), done_drive_low=1, rdy_busy=1, rdy_busy_oe=1, bit_valid=0, bit_out=0 and io_release=0.
- R2: The write strobe is active when wr_cs_n and wr_n are both 0. It passes through a two-flop synchronizer, and a byte is taken from wr_data when the synchronized strobe goes from inactive to active. With the strobe asserted just after a rising edge and held for four clocks, bit_valid first reads 1 after the third following rising edge.
- R3: An accepted byte appears on bit_out most significant bit first, on 8 consecutive clocks, with bit_valid=1 on each of them. bit_out is 0 whenever bit_valid is 0.
- R4: rdy_busy is 0 exactly while a byte is being shifted out and 1 otherwise. A write whose synchronized activation arrives while rdy_busy is 0 is ignored.
- R5: rdy_busy depends only on shifting. It reads 1 while the block is idle, even when done_in is held low.
- R6: done_drive_low is 1 from reset until cfg_len bytes have been accepted and the last one has been fully shifted out. It drops one clock after the last bit and never returns to 1 before the next reset. With cfg_len=0 it drops on the first clock after reset.
- R7: With sync_to_done=0, io_release rises exactly one clock after done_drive_low falls, whatever the level on done_in.
- R8: With sync_to_done=1, io_release stays 0 while done_in is low after DONE is released. It rises on the clock after done_in is first sampled high.
- R9: io_release rises only after done_drive_low is 0. rdy_busy_oe is 1 until io_release rises and 0 from then on.
- R10: Writes made after cfg_len bytes have been accepted are ignored and cause no bit_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cs_n | input | 1 | Host chip select, active low, asynchronous |
| wr_n | input | 1 | Host write, active low, asynchronous |
| wr_data | input | 8 | Host data byte, held stable while the strobe is active |
| cfg_len | input | 16 | Total configuration length in bytes |
| sync_to_done | input | 1 | 1: startup waits for the DONE pin to read high |
| done_in | input | 1 | Observed level of the DONE pin |
| done_drive_low | output | 1 | Pull-down enable of the open-drain DONE driver |
| rdy_busy | output | 1 | 1 ready, 0 busy shifting a byte |
| rdy_busy_oe | output | 1 | Output enable of the ready/busy pin |
| bit_out | output | 1 | Serial configuration bit |
| bit_valid | output | 1 | bit_out holds a valid bit this cycle |
| io_release | output | 1 | User I/Os released |

## Verification
The assertions check a fixed set of rules on every cycle:
- every run of valid bits is eight clocks long;
- a run only starts three cycles after an active strobe;
- DONE is released once and only after the last bit;
- no bit is emitted once DONE is released;
- I/O release follows a released DONE;
- the stall holds while the pin is low under sync-to-DONE.

Other properties only the bench scenarios show: a strobe arriving while busy is dropped, the exact bit content of the stream, ready staying high while DONE is held low externally, and I/O release one clock after the pin goes high. The same applies to the zero-length case and to writes made after the I/Os are released.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_CONFIG    = 3'd0,
        ST_REL_DONE  = 3'd1,
        ST_WAIT_DONE = 3'd2,
        ST_REL_IO    = 3'd3,
        ST_USER      = 3'd4
    } start_st_e;

endpackage

// File: rtl/cfg_strobe_sync.sv
module cfg_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic rise
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] remembers the previous synced value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              msb
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            s_d.sh  = {s_q.sh[DATA_W-2:0], 1'b0};
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST) s_d.busy = 1'b0;
        end else if (load) begin
            s_d.busy = 1'b1;
            s_d.sh   = din;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign msb  = s_q.busy & s_q.sh[DATA_W-1];
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
    import cfg_loader_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             shift_busy,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             sync_to_done,
    input  logic             done_in,
    output logic             room,
    output start_st_e        state
);
    typedef struct packed {
        start_st_e        st;
        logic [LEN_W-1:0] nbytes;
    } seq_t;

    seq_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        unique case (q_q.st)
            ST_CONFIG: begin
                if (accept)
                    q_d.nbytes = q_q.nbytes + 1'b1;
                else if (!shift_busy && (q_q.nbytes == cfg_len))
                    q_d.st = ST_REL_DONE;
            end
            ST_REL_DONE:  q_d.st = sync_to_done ? ST_WAIT_DONE : ST_REL_IO;
            ST_WAIT_DONE: if (done_in) q_d.st = ST_REL_IO;
            ST_REL_IO:    q_d.st = ST_USER;
            ST_USER:      q_d.st = ST_USER;
            default:      q_d.st = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.st     <= ST_CONFIG;
            q_q.nbytes <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign room  = (q_q.st == ST_CONFIG) && (q_q.nbytes < cfg_len);
    assign state = q_q.st;
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cs_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              sync_to_done,
    input  logic              done_in,
    output logic              done_drive_low,
    output logic              rdy_busy,
    output logic              rdy_busy_oe,
    output logic              bit_out,
    output logic              bit_valid,
    output logic              io_release
);
    logic      strobe_rise;
    logic      busy;
    logic      msb;
    logic      room;
    logic      accept;
    start_st_e state;

    cfg_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (~wr_cs_n & ~wr_n),
        .rise (strobe_rise)
    );

    assign accept = strobe_rise & ~busy & room;

    cfg_byte_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .din  (wr_data),
        .busy (busy),
        .msb  (msb)
    );

    cfg_startup_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .shift_busy  (busy),
        .cfg_len     (cfg_len),
        .sync_to_done(sync_to_done),
        .done_in     (done_in),
        .room        (room),
        .state       (state)
    );

    assign done_drive_low = (state == ST_CONFIG);
    assign io_release     = (state == ST_REL_IO) || (state == ST_USER);
    assign rdy_busy_oe    = ~io_release;
    assign rdy_busy       = ~busy;
    assign bit_valid      = busy;
    assign bit_out        = msb;
endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker #(
    parameter int DATA_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic wr_cs_n,
    input logic wr_n,
    input logic sync_to_done,
    input logic done_in,
    input logic done_drive_low,
    input logic bit_valid,
    input logic io_release
);
    localparam int RUN_W = $clog2(DATA_W + 2) + 1;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (bit_valid) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    assert_eight_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bit_valid) |-> (run_q == RUN_W'(DATA_W)));

    assert_strobe_before_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_valid) |-> $past(!wr_cs_n && !wr_n, 3));

    assert_release_after_last_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_drive_low) |-> $past(!bit_valid));

    assert_done_stays_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done_drive_low));

    assert_fast_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_to_done && $fell(done_drive_low)) |=> io_release);

    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_to_done && !done_in && !done_drive_low && !io_release) |=> !io_release);

    assert_io_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_release) |-> $past(!done_drive_low));

    assert_no_bits_after_config_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_drive_low |-> !bit_valid);
endmodule

bind cfg_byte_loader cfg_loader_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cfg_byte_loader_tb.sv
module cfg_byte_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_cs_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  wr_data = '0;
    logic [15:0] cfg_len = 16'd3;
    logic        sync_to_done = 1'b0;
    logic        ext_hold = 1'b1;
    logic        done_in;
    logic        done_drive_low, rdy_busy, rdy_busy_oe, bit_out, bit_valid, io_release;

    int total = 0, bad = 0, cycles = 0;
    bit cap[$];
    bit exp_bits[$];

    always #10 clk = ~clk;

    assign done_in = ~done_drive_low & ~ext_hold;

    cfg_byte_loader u_dut (
        .clk(clk), .rst_n(rst_n), .wr_cs_n(wr_cs_n), .wr_n(wr_n), .wr_data(wr_data),
        .cfg_len(cfg_len), .sync_to_done(sync_to_done), .done_in(done_in),
        .done_drive_low(done_drive_low), .rdy_busy(rdy_busy), .rdy_busy_oe(rdy_busy_oe),
        .bit_out(bit_out), .bit_valid(bit_valid), .io_release(io_release)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: strobe history, queue of pending bits, phase number
    int  m_s1, m_s2, m_s3, m_nbytes, m_ph;
    bit  m_q[$];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_nbytes = 0; m_ph = 0;
            m_q.delete();
        end else begin
            bit rise_m, was_busy;
            rise_m   = (m_s2 == 1) && (m_s3 == 0);
            was_busy = (m_q.size() != 0);
            if (was_busy) void'(m_q.pop_front());
            case (m_ph)
                0: begin
                    if (rise_m && !was_busy && m_nbytes < int'(cfg_len)) begin
                        for (int i = 7; i >= 0; i--) m_q.push_back(wr_data[i]);
                        m_nbytes++;
                    end else if (!was_busy && m_nbytes == int'(cfg_len)) begin
                        m_ph = 1;
                    end
                end
                1: m_ph = sync_to_done ? 2 : 3;
                2: if (done_in) m_ph = 3;
                3: m_ph = 4;
                default: m_ph = 4;
            endcase
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = (!wr_cs_n && !wr_n) ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit mv, mb;
            mv = (m_q.size() != 0);
            mb = mv ? m_q[0] : 1'b0;
            chk(rdy_busy == !mv, "R4 rdy_busy per cycle", rdy_busy, !mv);
            chk(bit_valid == mv, "R3 bit_valid per cycle", bit_valid, mv);
            chk(bit_out == mb, "R3 bit_out per cycle", bit_out, mb);
            chk(done_drive_low == (m_ph == 0), "R6 done_drive_low per cycle", done_drive_low, m_ph == 0);
            chk(io_release == (m_ph >= 3), "R9 io_release per cycle", io_release, m_ph >= 3);
            chk(rdy_busy_oe == (m_ph < 3), "R9 rdy_busy_oe per cycle", rdy_busy_oe, m_ph < 3);
            if (bit_valid) cap.push_back(bit_out);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(posedge clk); #2 rst_n = 1'b0;
        @(negedge clk);
        chk(done_drive_low == 1 && rdy_busy == 1 && rdy_busy_oe == 1 &&
            bit_valid == 0 && bit_out == 0 && io_release == 0,
            "R1 reset state", {done_drive_low, rdy_busy, rdy_busy_oe, bit_valid, bit_out, io_release},
            6'b111000);
        @(posedge clk); #2 rst_n = 1'b1;
        cap.delete();
        exp_bits.delete();
    endtask

    task automatic write_byte(input logic [7:0] d, input bit check_lat);
        @(posedge clk); #2;
        wr_data = d; wr_cs_n = 1'b0; wr_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (check_lat && k == 3) chk(bit_valid == 0, "R2 no bit before sync", bit_valid, 0);
            if (check_lat && k == 4) chk(bit_valid == 1, "R2 first bit latency", bit_valid, 1);
        end
        @(posedge clk); #2;
        wr_cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!rdy_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic push_exp(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) exp_bits.push_back(d[i]);
    endtask

    task automatic check_stream(input string tag);
        bit same;
        same = (cap.size() == exp_bits.size());
        if (same) foreach (cap[i]) if (cap[i] != exp_bits[i]) same = 0;
        chk(same, tag, cap.size(), exp_bits.size());
    endtask

    initial begin
        int n;
        // Test A: three bytes, sync off, DONE pin held low externally
        cfg_len = 16'd3; sync_to_done = 1'b0; ext_hold = 1'b1;
        do_reset();
        write_byte(8'hA5, 1'b1); push_exp(8'hA5);
        // strobe while busy: must be dropped (R4)
        @(posedge clk); #2 wr_data = 8'h00; wr_cs_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 wr_cs_n = 1'b1; wr_n = 1'b1;
        wait_ready();
        check_stream("R4 write while busy ignored");
        chk(rdy_busy == 1 && done_in == 0, "R5 ready with DONE pin low", rdy_busy, 1);
        write_byte(8'h3C, 1'b1); push_exp(8'h3C);
        wait_ready();
        chk(done_drive_low == 1, "R6 DONE held before count reached", done_drive_low, 1);
        write_byte(8'hFF, 1'b0); push_exp(8'hFF);
        while (done_drive_low) @(negedge clk);
        n = 0;
        while (!io_release) begin @(negedge clk); n++; end
        chk(n == 1, "R7 startup without DONE sampling", n, 1);
        check_stream("R3 MSB first stream");
        chk(rdy_busy_oe == 0, "R9 ready/busy released with I/Os", rdy_busy_oe, 0);
        write_byte(8'h77, 1'b0);
        repeat (12) @(negedge clk);
        check_stream("R10 write after configuration ignored");

        // Test B: two bytes, sync on, pin held low then let go
        cfg_len = 16'd2; sync_to_done = 1'b1; ext_hold = 1'b1;
        do_reset();
        write_byte(8'h81, 1'b1); push_exp(8'h81);
        wait_ready();
        write_byte(8'h6E, 1'b0); push_exp(8'h6E);
        while (done_drive_low) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(io_release == 0, "R8 stall while DONE pin low", io_release, 0);
        chk(rdy_busy == 1 && rdy_busy_oe == 1, "R5 ready during stall", rdy_busy, 1);
        check_stream("R3 stream with sync on");
        @(posedge clk); #2 ext_hold = 1'b0;
        @(negedge clk);
        chk(io_release == 0, "R8 not yet released", io_release, 0);
        @(negedge clk);
        chk(io_release == 1, "R8 release one clock after pin high", io_release, 1);

        // Test C: zero length
        cfg_len = 16'd0; sync_to_done = 1'b0; ext_hold = 1'b0;
        do_reset();
        @(negedge clk);
        chk(done_drive_low == 1, "R6 zero length before first edge", done_drive_low, 1);
        @(negedge clk);
        chk(done_drive_low == 0, "R6 zero length released", done_drive_low, 0);
        repeat (3) @(negedge clk);
        chk(io_release == 1, "R9 zero length I/O release", io_release, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule